// File: doc/BRIEF.md
# Multi-Core Halt Power State Controller

This block sequences the low-power states of a processor package that holds a parameterised number of logical cores. The package drops into a halt state only once every core reports itself halted. A set of wake events brings it back to normal running. An external stop-clock request can park the package one level deeper, and snoops keep being answered while the cores sleep.

When the enhanced mode is on, the controller moves through a two-step operating-point change. It lowers the core clock ratio and waits for the clock logic to confirm, then lowers the voltage ID and waits again. Leaving the state walks the same steps in reverse, voltage first and ratio second, and restores the exact values captured at entry. The bus clock select never moves. Every step waits for a done handshake from the clock or voltage hardware outside the block. A wake that arrives while the entry is still in progress is remembered, and it turns the sequence around as soon as the step in progress completes.

Top module: `halt_power_ctrl`

## Requirements
- R1: `rst` is synchronous and active high. At the first clock edge it sees, it forces `pwr_state` to Normal from any state, with no sequencing. It also sets `ratio_sel` to RATIO_RST, `vid_sel` to VID_RST, clears `snoop_svc` and sets the enhanced enable to 1. The state codes are Normal=0, Halt=1, RatioDown=2, VoltDown=3, EnhHalt=4, VoltUp=5, RatioUp=6, StopGrant=7.
- R2: In Normal, the package leaves Normal toward a halt state only when every bit of `core_halt` is 1. With some bits at 0 it stays in Normal.
- R3: In Halt, any one of `wake_smi`, `wake_binit`, `wake_init`, `wake_lint[0]`, `wake_lint[1]` or `wake_busmsg` moves the state to Normal at the next edge. In Normal, an active wake blocks entry into any halt state.
- R4: In Normal with no wake active, `smi_ret` high moves the state to Halt if `smi_ret_halt` is 1 and leaves it in Normal if `smi_ret_halt` is 0. This takes precedence over the all-halted condition.
- R5: In Halt, `stpclk_req` high moves the state to StopGrant. StopGrant returns to Halt, and never to Normal, when `stpclk_req` falls. Wake events have no effect in StopGrant.
- R6: `snoop_svc` is 1 in the cycle after `snoop_req` was 1, provided the state in that earlier cycle was not StopGrant. Snoops are therefore answered in Normal, Halt, EnhHalt and all transition states.
- R7: With the enhanced enable at 1, reaching the all-halted condition goes to RatioDown with `ratio_sel` set to `ratio_low` and `vid_sel` unchanged. On `ratio_done` the state goes to VoltDown with `vid_sel` set to `vid_low`. On `vid_done` it goes to EnhHalt. Each state holds until its done input is seen, and `ratio_low` and `vid_low` are held steady during a sequence.
- R8: A wake in EnhHalt goes to VoltUp with `vid_sel` restored. On `vid_done` the state goes to RatioUp with `ratio_sel` restored. On `ratio_done` it goes to Normal. The restored values are the ones captured at entry, even if `ratio_nom` or `vid_nom` has changed since.
- R9: A wake seen in RatioDown or VoltDown, even one that lasts a single cycle, is latched. When the current done arrives, RatioDown goes to RatioUp and restores the ratio, and VoltDown goes to VoltUp and restores the voltage.
- R10: A `cfg_enh_wr` cycle loads `cfg_enh_val` into the enhanced enable. With the enable at 0, the all-halted condition leads to Halt, and `ratio_sel` and `vid_sel` hold their values through Halt and StopGrant.
- R11: `fsb_sel` equals the FSB_SEL parameter in every state.
- R12: In Normal, `ratio_sel` and `vid_sel` follow `ratio_nom` and `vid_nom` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core_halt | input | NCORES | Per-core halted flag |
| wake_smi | input | 1 | System management interrupt wake |
| wake_binit | input | 1 | Bus init wake |
| wake_init | input | 1 | Init wake |
| wake_lint | input | 2 | Local interrupt lines (NMI, INTR) |
| wake_busmsg | input | 1 | Interrupt message from the front-side bus |
| smi_ret | input | 1 | Return from SMI handling |
| smi_ret_halt | input | 1 | Return target: 1 = Halt, 0 = Normal |
| stpclk_req | input | 1 | Stop-clock request |
| snoop_req | input | 1 | Snoop request |
| cfg_enh_wr | input | 1 | Load strobe for the enhanced enable |
| cfg_enh_val | input | 1 | Enhanced enable value |
| ratio_nom | input | RATIO_W | Nominal core ratio |
| vid_nom | input | VID_W | Nominal voltage ID |
| ratio_low | input | RATIO_W | Low core ratio for enhanced halt |
| vid_low | input | VID_W | Low voltage ID for enhanced halt |
| ratio_done | input | 1 | Ratio change complete |
| vid_done | input | 1 | Voltage change complete |
| pwr_state | output | 3 | Current state code |
| ratio_sel | output | RATIO_W | Core ratio select |
| vid_sel | output | VID_W | Voltage ID select |
| fsb_sel | output | FSB_W | Bus clock select (constant) |
| snoop_svc | output | 1 | Snoop being serviced |

## Verification
The halt entry is driven with a partial halt mask, a full mask with the enhanced mode off, and a full mask with the mode on. This separates the all-cores gate from the choice between plain and enhanced halt. Each of the six wake sources is pulsed alone from Halt. A wake is also sent into StopGrant, where it must be ignored. This shows which states answer wakes and which wait for the stop-clock request to fall. The enhanced sequence is run three ways: to completion with the done inputs delayed, with a one-cycle wake during RatioDown, and with a wake during VoltDown. The nominal ratio is changed mid-sleep, which shows whether the exit restores the captured values rather than live ones, and whether the ratio and voltage steps keep their order.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_HALT   = 3'd1,
        ST_RDN    = 3'd2,
        ST_VDN    = 3'd3,
        ST_EHALT  = 3'd4,
        ST_VUP    = 3'd5,
        ST_RUP    = 3'd6,
        ST_STOP   = 3'd7
    } hpc_state_e;

    typedef enum logic [2:0] {
        OP_TRACK,
        OP_HOLD,
        OP_LOW_RATIO,
        OP_LOW_VID,
        OP_REST_VID,
        OP_REST_RATIO
    } opp_cmd_e;

    typedef struct packed {
        logic       smi;
        logic       binit;
        logic       init;
        logic [1:0] lint;
        logic       busmsg;
    } wake_s;

    function automatic logic is_entry(hpc_state_e s);
        return (s == ST_RDN) || (s == ST_VDN);
    endfunction

    function automatic logic any_wake(wake_s w);
        return w.smi | w.binit | w.init | (|w.lint) | w.busmsg;
    endfunction

endpackage

// File: rtl/hpc_halt_detect.sv
module hpc_halt_detect #(
    parameter int NCORES = 2
) (
    input  logic [NCORES-1:0] core_halt,
    output logic              all_halt
);
    logic [NCORES:0] chain;

    assign chain[0] = 1'b1;
    for (genvar g = 0; g < NCORES; g++) begin : g_chain
        assign chain[g+1] = chain[g] & core_halt[g];
    end
    assign all_halt = chain[NCORES];
endmodule

// File: rtl/hpc_wake_merge.sv
module hpc_wake_merge
    import hpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wake_s      wake,
    input  hpc_state_e state,
    output logic       wake_now,
    output logic       wake_pend
);
    logic pend_q;
    logic track_en;

    assign wake_now  = any_wake(wake);
    assign track_en  = is_entry(state);
    assign wake_pend = pend_q | wake_now;

    always_ff @(posedge clk) begin
        if (rst)           pend_q <= 1'b0;
        else if (track_en) pend_q <= pend_q | wake_now;
        else               pend_q <= 1'b0;
    end

    // R9: a wake seen during entry is remembered at the next cycle
    a_r9_wake_latched: assert property (@(posedge clk) disable iff (rst)
        (track_en && wake_now) |=> pend_q);
endmodule

// File: rtl/hpc_opp_regs.sv
module hpc_opp_regs
    import hpc_pkg::*;
#(
    parameter int                RATIO_W   = 6,
    parameter int                VID_W     = 8,
    parameter logic [RATIO_W-1:0] RATIO_RST = '0,
    parameter logic [VID_W-1:0]   VID_RST   = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  opp_cmd_e           cmd,
    input  logic [RATIO_W-1:0] ratio_nom,
    input  logic [VID_W-1:0]   vid_nom,
    input  logic [RATIO_W-1:0] ratio_low,
    input  logic [VID_W-1:0]   vid_low,
    output logic [RATIO_W-1:0] ratio_sel,
    output logic [VID_W-1:0]   vid_sel
);
    logic [RATIO_W-1:0] ratio_q, save_r;
    logic [VID_W-1:0]   vid_q, save_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= RATIO_RST;
            vid_q   <= VID_RST;
            save_r  <= RATIO_RST;
            save_v  <= VID_RST;
        end else begin
            unique case (cmd)
                OP_TRACK: begin
                    ratio_q <= ratio_nom;
                    vid_q   <= vid_nom;
                end
                OP_LOW_RATIO: begin
                    save_r  <= ratio_q;
                    save_v  <= vid_q;
                    ratio_q <= ratio_low;
                end
                OP_LOW_VID:    vid_q   <= vid_low;
                OP_REST_VID:   vid_q   <= save_v;
                OP_REST_RATIO: ratio_q <= save_r;
                default: ;
            endcase
        end
    end

    assign ratio_sel = ratio_q;
    assign vid_sel   = vid_q;

    // R7: voltage is lowered only after the ratio already sits low
    a_r7_ratio_before_vid: assert property (@(posedge clk) disable iff (rst)
        (cmd == OP_LOW_VID) |-> (ratio_q == ratio_low));
    // R8: ratio is restored only once the voltage is back at its captured value
    a_r8_vid_before_ratio: assert property (@(posedge clk) disable iff (rst)
        (cmd == OP_REST_RATIO) |-> (vid_q == save_v));
endmodule

// File: rtl/hpc_fsm.sv
module hpc_fsm
    import hpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       all_halt,
    input  logic       wake_now,
    input  logic       wake_pend,
    input  logic       smi_ret,
    input  logic       smi_ret_halt,
    input  logic       stpclk_req,
    input  logic       ratio_done,
    input  logic       vid_done,
    input  logic       cfg_enh_wr,
    input  logic       cfg_enh_val,
    input  logic       snoop_req,
    output hpc_state_e state,
    output opp_cmd_e   cmd,
    output logic       snoop_svc
);
    hpc_state_e state_q, nxt;
    logic       enh_q;
    logic       svc_q;

    always_comb begin
        nxt = state_q;
        cmd = OP_HOLD;
        unique case (state_q)
            ST_NORMAL: begin
                cmd = OP_TRACK;
                if (!wake_now) begin
                    if (smi_ret) begin
                        if (smi_ret_halt) begin
                            nxt = ST_HALT;
                            cmd = OP_HOLD;
                        end
                    end else if (all_halt) begin
                        if (enh_q) begin
                            nxt = ST_RDN;
                            cmd = OP_LOW_RATIO;
                        end else begin
                            nxt = ST_HALT;
                            cmd = OP_HOLD;
                        end
                    end
                end
            end
            ST_HALT: begin
                if (wake_now)        nxt = ST_NORMAL;
                else if (stpclk_req) nxt = ST_STOP;
            end
            ST_STOP: begin
                if (!stpclk_req) nxt = ST_HALT;
            end
            ST_RDN: begin
                if (ratio_done) begin
                    if (wake_pend) begin
                        nxt = ST_RUP;
                        cmd = OP_REST_RATIO;
                    end else begin
                        nxt = ST_VDN;
                        cmd = OP_LOW_VID;
                    end
                end
            end
            ST_VDN: begin
                if (vid_done) begin
                    if (wake_pend) begin
                        nxt = ST_VUP;
                        cmd = OP_REST_VID;
                    end else begin
                        nxt = ST_EHALT;
                    end
                end
            end
            ST_EHALT: begin
                if (wake_now) begin
                    nxt = ST_VUP;
                    cmd = OP_REST_VID;
                end
            end
            ST_VUP: begin
                if (vid_done) begin
                    nxt = ST_RUP;
                    cmd = OP_REST_RATIO;
                end
            end
            ST_RUP: begin
                if (ratio_done) nxt = ST_NORMAL;
            end
            default: nxt = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_NORMAL;
            enh_q   <= 1'b1;
            svc_q   <= 1'b0;
        end else begin
            state_q <= nxt;
            if (cfg_enh_wr) enh_q <= cfg_enh_val;
            svc_q <= snoop_req && (state_q != ST_STOP);
        end
    end

    assign state     = state_q;
    assign snoop_svc = svc_q;

    // R1: one reset cycle lands in Normal
    a_r1_reset_normal: assert property (@(posedge clk)
        $past(rst) |-> (state_q == ST_NORMAL));
    // R2: the step from Normal into Halt needs all cores halted or an SMI return
    a_r2_halt_gate: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_NORMAL && state_q == ST_HALT) |-> ($past(all_halt) || $past(smi_ret)));
    // R5: StopGrant is reached only from Halt
    a_r5_stop_from_halt: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOP) |-> ($past(state_q) == ST_HALT || $past(state_q) == ST_STOP));
    // R6: a serviced snoop had a request outside StopGrant one cycle before
    a_r6_snoop_origin: assert property (@(posedge clk) disable iff (rst)
        svc_q |-> ($past(snoop_req) && $past(state_q) != ST_STOP));
endmodule

// File: rtl/halt_power_ctrl.sv
module halt_power_ctrl
    import hpc_pkg::*;
#(
    parameter int                 NCORES    = 2,
    parameter int                 RATIO_W   = 6,
    parameter int                 VID_W     = 8,
    parameter int                 FSB_W     = 2,
    parameter logic [FSB_W-1:0]   FSB_SEL   = 2'd1,
    parameter logic [RATIO_W-1:0] RATIO_RST = 6'd16,
    parameter logic [VID_W-1:0]   VID_RST   = 8'd90
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NCORES-1:0]  core_halt,
    input  logic               wake_smi,
    input  logic               wake_binit,
    input  logic               wake_init,
    input  logic [1:0]         wake_lint,
    input  logic               wake_busmsg,
    input  logic               smi_ret,
    input  logic               smi_ret_halt,
    input  logic               stpclk_req,
    input  logic               snoop_req,
    input  logic               cfg_enh_wr,
    input  logic               cfg_enh_val,
    input  logic [RATIO_W-1:0] ratio_nom,
    input  logic [VID_W-1:0]   vid_nom,
    input  logic [RATIO_W-1:0] ratio_low,
    input  logic [VID_W-1:0]   vid_low,
    input  logic               ratio_done,
    input  logic               vid_done,
    output logic [2:0]         pwr_state,
    output logic [RATIO_W-1:0] ratio_sel,
    output logic [VID_W-1:0]   vid_sel,
    output logic [FSB_W-1:0]   fsb_sel,
    output logic               snoop_svc
);
    wake_s      wake;
    logic       all_halt, wake_now, wake_pend;
    hpc_state_e state;
    opp_cmd_e   cmd;

    assign wake = '{smi: wake_smi, binit: wake_binit, init: wake_init,
                    lint: wake_lint, busmsg: wake_busmsg};

    hpc_halt_detect #(.NCORES(NCORES)) u_detect (
        .core_halt (core_halt),
        .all_halt  (all_halt)
    );

    hpc_wake_merge u_wake (
        .clk       (clk),
        .rst       (rst),
        .wake      (wake),
        .state     (state),
        .wake_now  (wake_now),
        .wake_pend (wake_pend)
    );

    hpc_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .all_halt     (all_halt),
        .wake_now     (wake_now),
        .wake_pend    (wake_pend),
        .smi_ret      (smi_ret),
        .smi_ret_halt (smi_ret_halt),
        .stpclk_req   (stpclk_req),
        .ratio_done   (ratio_done),
        .vid_done     (vid_done),
        .cfg_enh_wr   (cfg_enh_wr),
        .cfg_enh_val  (cfg_enh_val),
        .snoop_req    (snoop_req),
        .state        (state),
        .cmd          (cmd),
        .snoop_svc    (snoop_svc)
    );

    hpc_opp_regs #(
        .RATIO_W   (RATIO_W),
        .VID_W     (VID_W),
        .RATIO_RST (RATIO_RST),
        .VID_RST   (VID_RST)
    ) u_opp (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .ratio_nom (ratio_nom),
        .vid_nom   (vid_nom),
        .ratio_low (ratio_low),
        .vid_low   (vid_low),
        .ratio_sel (ratio_sel),
        .vid_sel   (vid_sel)
    );

    assign pwr_state = state;
    assign fsb_sel   = FSB_SEL;
endmodule

// File: tb/halt_power_ctrl_tb_top.sv
module halt_power_ctrl_tb_top;
    localparam int NC = 2;
    localparam int RW = 6;
    localparam int VW = 8;
    localparam int RRST = 16;
    localparam int VRST = 90;
    localparam int FSB = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NC-1:0] core_halt = '0;
    logic wake_smi = 0, wake_binit = 0, wake_init = 0, wake_busmsg = 0;
    logic [1:0] wake_lint = '0;
    logic smi_ret = 0, smi_ret_halt = 0, stpclk_req = 0, snoop_req = 0;
    logic cfg_enh_wr = 0, cfg_enh_val = 0;
    logic [RW-1:0] ratio_nom = 6'd20, ratio_low = 6'd8;
    logic [VW-1:0] vid_nom = 8'd100, vid_low = 8'd60;
    logic ratio_done = 0, vid_done = 0;
    logic [2:0] pwr_state;
    logic [RW-1:0] ratio_sel;
    logic [VW-1:0] vid_sel;
    logic [1:0] fsb_sel;
    logic snoop_svc;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 0;

    always #5 clk = ~clk;

    halt_power_ctrl #(.NCORES(NC), .RATIO_W(RW), .VID_W(VW)) dut_i (
        .clk(clk), .rst(rst), .core_halt(core_halt),
        .wake_smi(wake_smi), .wake_binit(wake_binit), .wake_init(wake_init),
        .wake_lint(wake_lint), .wake_busmsg(wake_busmsg),
        .smi_ret(smi_ret), .smi_ret_halt(smi_ret_halt), .stpclk_req(stpclk_req),
        .snoop_req(snoop_req), .cfg_enh_wr(cfg_enh_wr), .cfg_enh_val(cfg_enh_val),
        .ratio_nom(ratio_nom), .vid_nom(vid_nom), .ratio_low(ratio_low), .vid_low(vid_low),
        .ratio_done(ratio_done), .vid_done(vid_done),
        .pwr_state(pwr_state), .ratio_sel(ratio_sel), .vid_sel(vid_sel),
        .fsb_sel(fsb_sel), .snoop_svc(snoop_svc)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_st = 0, m_r = RRST, m_v = VRST, m_sr = RRST, m_sv = VRST;
    int m_pend = 0, m_enh = 1, m_snp = 0;

    always @(posedge clk) begin
        int wk, all, nst, nr, nv, nsr, nsv, np;
        wk  = (wake_smi || wake_binit || wake_init || wake_lint != 0 || wake_busmsg) ? 1 : 0;
        all = (core_halt == {NC{1'b1}}) ? 1 : 0;
        if (rst) begin
            m_st = 0; m_r = RRST; m_v = VRST; m_sr = RRST; m_sv = VRST;
            m_pend = 0; m_enh = 1; m_snp = 0;
        end else begin
            nst = m_st; nr = m_r; nv = m_v; nsr = m_sr; nsv = m_sv; np = 0;
            case (m_st)
                0: begin
                    nr = int'(ratio_nom); nv = int'(vid_nom);
                    if (wk == 0) begin
                        if (smi_ret) begin
                            if (smi_ret_halt) begin nst = 1; nr = m_r; nv = m_v; end
                        end else if (all == 1) begin
                            if (m_enh == 1) begin
                                nst = 2; nsr = m_r; nsv = m_v; nr = int'(ratio_low); nv = m_v;
                            end else begin
                                nst = 1; nr = m_r; nv = m_v;
                            end
                        end
                    end
                end
                1: if (wk == 1) nst = 0; else if (stpclk_req) nst = 7;
                7: if (!stpclk_req) nst = 1;
                2: begin
                    np = (m_pend == 1 || wk == 1) ? 1 : 0;
                    if (ratio_done) begin
                        if (np == 1) begin nst = 6; nr = m_sr; end
                        else begin nst = 3; nv = int'(vid_low); end
                    end
                end
                3: begin
                    np = (m_pend == 1 || wk == 1) ? 1 : 0;
                    if (vid_done) begin
                        if (np == 1) begin nst = 5; nv = m_sv; end
                        else nst = 4;
                    end
                end
                4: if (wk == 1) begin nst = 5; nv = m_sv; end
                5: if (vid_done) begin nst = 6; nr = m_sr; end
                6: if (ratio_done) nst = 0;
                default: nst = 0;
            endcase
            m_snp = (snoop_req && m_st != 7) ? 1 : 0;
            if (cfg_enh_wr) m_enh = cfg_enh_val ? 1 : 0;
            m_st = nst; m_r = nr; m_v = nv; m_sr = nsr; m_sv = nsv; m_pend = np;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2", "model state", int'(pwr_state), m_st);
            chk("R7", "model ratio", int'(ratio_sel), m_r);
            chk("R8", "model vid", int'(vid_sel), m_v);
            chk("R6", "model snoop", int'(snoop_svc), m_snp);
            chk("R11", "fsb", int'(fsb_sel), FSB);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic run();
        tick(); tick();
        // R1 reset state
        chk("R1", "reset state", int'(pwr_state), 0);
        chk("R1", "reset ratio", int'(ratio_sel), RRST);
        chk("R1", "reset vid", int'(vid_sel), VRST);
        chk("R1", "reset snoop", int'(snoop_svc), 0);
        cmp_en = 1;
        rst = 0;
        tick();
        chk("R12", "ratio tracks nominal", int'(ratio_sel), 20);
        chk("R12", "vid tracks nominal", int'(vid_sel), 100);
        // R2 partial halt
        core_halt = 2'b01; tick(); tick();
        chk("R2", "partial halt stays normal", int'(pwr_state), 0);
        // R10 disable enhanced
        cfg_enh_wr = 1; cfg_enh_val = 0; tick();
        cfg_enh_wr = 0; core_halt = 2'b11; tick();
        chk("R10", "plain halt", int'(pwr_state), 1);
        ratio_nom = 6'd25; tick();
        chk("R10", "ratio held in halt", int'(ratio_sel), 20);
        chk("R10", "vid held in halt", int'(vid_sel), 100);
        snoop_req = 1; tick();
        chk("R6", "snoop in halt", int'(snoop_svc), 1);
        snoop_req = 0; stpclk_req = 1; tick();
        chk("R5", "stop grant", int'(pwr_state), 7);
        wake_smi = 1; snoop_req = 1; tick();
        chk("R5", "wake ignored in stop", int'(pwr_state), 7);
        chk("R6", "no snoop in stop", int'(snoop_svc), 0);
        wake_smi = 0; snoop_req = 0; stpclk_req = 0; tick();
        chk("R5", "stop back to halt", int'(pwr_state), 1);
        // R3 each wake source
        for (int i = 0; i < 6; i++) begin
            case (i)
                0: wake_smi = 1;
                1: wake_binit = 1;
                2: wake_init = 1;
                3: wake_lint = 2'b01;
                4: wake_lint = 2'b10;
                default: wake_busmsg = 1;
            endcase
            tick();
            chk("R3", $sformatf("wake source %0d", i), int'(pwr_state), 0);
            wake_smi = 0; wake_binit = 0; wake_init = 0; wake_lint = 0; wake_busmsg = 0;
            tick();
            chk("R2", "re-enter halt", int'(pwr_state), 1);
        end
        // R4 SMI return target
        core_halt = 2'b00; wake_smi = 1; tick();
        wake_smi = 0; smi_ret = 1; smi_ret_halt = 0; tick();
        chk("R4", "return to normal", int'(pwr_state), 0);
        smi_ret_halt = 1; tick();
        chk("R4", "return to halt", int'(pwr_state), 1);
        smi_ret = 0; smi_ret_halt = 0;
        // R1 reset from a halt state
        rst = 1; tick();
        chk("R1", "reset from halt", int'(pwr_state), 0);
        rst = 0; ratio_nom = 6'd20; tick(); tick();
        // R7 enhanced entry, enable back at 1 after reset (R10)
        core_halt = 2'b11; tick();
        chk("R10", "enable resets to 1", int'(pwr_state), 2);
        chk("R7", "ratio lowered first", int'(ratio_sel), 8);
        chk("R7", "vid unchanged at first step", int'(vid_sel), 100);
        tick();
        chk("R7", "waits for ratio done", int'(pwr_state), 2);
        ratio_done = 1; tick();
        ratio_done = 0;
        chk("R7", "volt down state", int'(pwr_state), 3);
        chk("R7", "vid lowered", int'(vid_sel), 60);
        tick();
        chk("R7", "waits for vid done", int'(pwr_state), 3);
        vid_done = 1; tick();
        vid_done = 0;
        chk("R7", "enhanced halt", int'(pwr_state), 4);
        snoop_req = 1; tick();
        snoop_req = 0;
        chk("R6", "snoop in enhanced halt", int'(snoop_svc), 1);
        // R8 exit ordering with captured values
        ratio_nom = 6'd30; core_halt = 2'b00; wake_busmsg = 1; tick();
        wake_busmsg = 0;
        chk("R8", "volt up state", int'(pwr_state), 5);
        chk("R8", "vid restored first", int'(vid_sel), 100);
        chk("R8", "ratio still low", int'(ratio_sel), 8);
        vid_done = 1; tick();
        vid_done = 0;
        chk("R8", "ratio up state", int'(pwr_state), 6);
        chk("R8", "captured ratio restored", int'(ratio_sel), 20);
        ratio_done = 1; tick();
        ratio_done = 0;
        chk("R8", "back to normal", int'(pwr_state), 0);
        tick();
        chk("R12", "tracks new nominal", int'(ratio_sel), 30);
        // R9 wake during ratio step
        core_halt = 2'b11; tick();
        chk("R9", "entry started", int'(pwr_state), 2);
        core_halt = 2'b00; wake_init = 1; tick();
        wake_init = 0; tick();
        chk("R9", "still waiting ratio", int'(pwr_state), 2);
        ratio_done = 1; tick();
        chk("R9", "abort to ratio up", int'(pwr_state), 6);
        chk("R9", "ratio restored", int'(ratio_sel), 30);
        tick();
        ratio_done = 0;
        chk("R9", "normal after abort", int'(pwr_state), 0);
        // R9 wake during voltage step
        core_halt = 2'b11; tick();
        ratio_done = 1; tick();
        ratio_done = 0;
        chk("R9", "volt down", int'(pwr_state), 3);
        core_halt = 2'b00; wake_lint = 2'b01; tick();
        wake_lint = 0; vid_done = 1; tick();
        chk("R9", "abort to volt up", int'(pwr_state), 5);
        chk("R9", "vid restored", int'(vid_sel), 100);
        tick();
        vid_done = 0; ratio_done = 1;
        chk("R9", "ratio up after vid", int'(pwr_state), 6);
        tick();
        ratio_done = 0;
        chk("R9", "normal after second abort", int'(pwr_state), 0);
        chk("R11", "fsb constant", int'(fsb_sel), FSB);
        tick();
    endtask

    initial begin
        fork
            run();
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule